// File: doc/BRIEF.md
# Audio Source Selection Mode Controller

This block holds the routing decisions of a multichannel television sound decoder. Three carrier detector flags come in as asynchronous levels: stereo pilot present, second-program carrier present, and second-program noise high. A handful of control bits set by firmware come in alongside them. From these the block picks what feeds the noise-reduction expander (the difference signal, the second program, or nothing), which source each loudspeaker channel carries, and whether the second-program output gets its soft attenuation. The analog paths are steered by these codes and are not part of the block.

Each detector flag passes through a two-stage synchroniser and then a debounce filter. A new flag level counts only once it has held for `hold_count` clocks. The filtered flags and the control bits drive a three-state mode register: MS_MAIN_MONO (sum signal on both speakers), MS_MAIN_STEREO (left and right decoded separately) and MS_SAP_PROG (second program selected). The next state is worked out afresh on every clock from the current inputs. Any state can move to any other in one edge: a transition to MS_SAP_PROG when second-program output is chosen, to MS_MAIN_STEREO when a stereo pilot is accepted and mono is not forced, and to MS_MAIN_MONO otherwise. Speaker mute and external-input selection are applied on top of the state's matrix choice, with mute taking priority.

Top module: `audio_route_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0: `nr_src`=0, both speaker codes 0 (mute), `sap_soft_mute`=0.
- R2: A detector flag is sampled by two flip-flops and accepted only after the synchronised level has differed from the accepted level for `hold_count` consecutive clocks (0 is treated as 1). A shorter pulse leaves the outputs unchanged.
- R3: Speaker codes are 0 mute, 1 left, 2 right, 3 sum (L+R), 4 second program, 5 external. Expander codes are 0 off, 1 difference (L-R), 2 second program; code 3 never appears. When second program is not selected, the stereo flag is 1 and `force_mono`=0, `nr_src`=1, the left code is 1 and the right code is 2.
- R4: When second program is not selected and either the stereo flag is 0 or `force_mono`=1, `nr_src`=0 and both speaker codes are 3.
- R5: With `sap_always`=1 and `sap_request`=1, second program is selected whatever the carrier flag says. `nr_src`=2, and both speakers are 4, or left 3 and right 4 when `force_mono`=1.
- R6: With `sap_always`=0 and `sap_request`=1, second program is selected only when the accepted carrier flag is 1. Otherwise the result is as in R3/R4.
- R7: `sap_soft_mute` is 1 exactly when second program is selected and (noise flag is 1 or carrier flag is 0).
- R8: `spk_enable`=0 forces both speaker codes to 0 whatever `ext_select` is; `nr_src` and `sap_soft_mute` are unaffected.
- R9: `spk_enable`=1 with `ext_select`=1 sets both speaker codes to 5; `nr_src` is unaffected.
- R10: Outputs are registered. A control-bit change shows at the outputs after the next rising clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_count | input | HOLD_W (8) | Debounce length in clocks, 0 acts as 1 |
| stereo_det | input | 1 | Asynchronous stereo pilot detector flag |
| sap_det | input | 1 | Asynchronous second-program carrier flag |
| noise_det | input | 1 | Asynchronous second-program noise flag |
| sap_request | input | 1 | Firmware asks for second-program output |
| force_mono | input | 1 | Firmware forces mono on the main program |
| sap_always | input | 1 | Select second program without a confirmed carrier |
| spk_enable | input | 1 | 0 mutes both speaker channels |
| ext_select | input | 1 | 1 routes the external inputs to the speakers |
| nr_src | output | 2 | Expander input code |
| spk_left_src | output | 3 | Left speaker source code |
| spk_right_src | output | 3 | Right speaker source code |
| sap_soft_mute | output | 1 | Soft attenuation enable for the second program |

## Verification
The assertions assume that the control bits and `hold_count` are synchronous to `clk`. They also assume that `hold_count` stays fixed while a flag is being debounced, so that the filter's count refers to one threshold. Only the three detector flags may change asynchronously. The stimulus changes every input on the falling clock edge and sets `hold_count` once, before reset is released. Flags are held for well over the threshold, except in the deliberate short-pulse case.

// File: rtl/audio_route_pkg.sv
package audio_route_pkg;

    typedef enum logic [2:0] {
        SRC_MUTE  = 3'd0,
        SRC_LEFT  = 3'd1,
        SRC_RIGHT = 3'd2,
        SRC_SUM   = 3'd3,
        SRC_SAP   = 3'd4,
        SRC_EXT   = 3'd5
    } spk_src_t;

    typedef enum logic [1:0] {
        NR_OFF  = 2'd0,
        NR_DIFF = 2'd1,
        NR_SAP  = 2'd2
    } nr_src_t;

    typedef enum logic [1:0] {
        MS_MAIN_MONO   = 2'd0,
        MS_MAIN_STEREO = 2'd1,
        MS_SAP_PROG    = 2'd2
    } mode_state_t;

    localparam int unsigned FLAG_COUNT = 3;
    localparam int unsigned FLAG_STEREO = 0;
    localparam int unsigned FLAG_SAP    = 1;
    localparam int unsigned FLAG_NOISE  = 2;

endpackage

// File: rtl/flag_debounce.sv
module flag_debounce #(
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] hold_count,
    input  logic              raw_flag,
    output logic              clean_flag
);

    localparam int unsigned SYNC_STAGES = 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HOLD_W-1:0]      run_q;
    logic [HOLD_W-1:0]      limit;
    logic                   sync_lvl;

    assign sync_lvl = sync_q[SYNC_STAGES-1];
    assign limit    = (hold_count == '0) ? '0 : hold_count - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= '0;
            run_q      <= '0;
            clean_flag <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_flag};
            if (sync_lvl != clean_flag) begin
                if (run_q >= limit) begin
                    clean_flag <= sync_lvl;
                    run_q      <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    // R2: an accepted level always equals what the synchroniser showed
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean_flag) |-> ($past(sync_lvl) == clean_flag));

endmodule

// File: rtl/route_fsm.sv
module route_fsm
    import audio_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stereo_ok,
    input  logic       sap_ok,
    input  logic       noise_ok,
    input  logic       sap_request,
    input  logic       force_mono,
    input  logic       sap_always,
    input  logic       spk_enable,
    input  logic       ext_select,
    output logic [1:0] nr_src,
    output logic [2:0] spk_left_src,
    output logic [2:0] spk_right_src,
    output logic       sap_soft_mute
);

    mode_state_t state_q, state_d;
    logic        mono_q, enable_q, ext_q, soft_q;
    logic        sap_pick, soft_d;
    spk_src_t    left_sel, right_sel;
    nr_src_t     nr_sel;

    always_comb begin
        sap_pick = sap_request && (sap_always || sap_ok);
        soft_d   = sap_pick && (noise_ok || !sap_ok);
        if (sap_pick)
            state_d = MS_SAP_PROG;
        else if (stereo_ok && !force_mono)
            state_d = MS_MAIN_STEREO;
        else
            state_d = MS_MAIN_MONO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= MS_MAIN_MONO;
            mono_q   <= 1'b0;
            enable_q <= 1'b0;
            ext_q    <= 1'b0;
            soft_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            mono_q   <= force_mono;
            enable_q <= spk_enable;
            ext_q    <= ext_select;
            soft_q   <= soft_d;
        end
    end

    always_comb begin
        unique case (state_q)
            MS_MAIN_STEREO: begin
                nr_sel    = NR_DIFF;
                left_sel  = SRC_LEFT;
                right_sel = SRC_RIGHT;
            end
            MS_SAP_PROG: begin
                nr_sel    = NR_SAP;
                left_sel  = mono_q ? SRC_SUM : SRC_SAP;
                right_sel = SRC_SAP;
            end
            default: begin
                nr_sel    = NR_OFF;
                left_sel  = SRC_SUM;
                right_sel = SRC_SUM;
            end
        endcase
        if (!enable_q) begin
            left_sel  = SRC_MUTE;
            right_sel = SRC_MUTE;
        end else if (ext_q) begin
            left_sel  = SRC_EXT;
            right_sel = SRC_EXT;
        end
        // Reset value of enable_q mutes the speakers (R1)
    end

    assign nr_src        = nr_sel;
    assign spk_left_src  = left_sel;
    assign spk_right_src = right_sel;
    assign sap_soft_mute = soft_q;

    p_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !spk_enable |=> (spk_left_src == SRC_MUTE) && (spk_right_src == SRC_MUTE));

    p_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (spk_enable && ext_select) |=> (spk_left_src == SRC_EXT) && (spk_right_src == SRC_EXT));

    p_sap_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sap_request && sap_always) |=> (nr_src == NR_SAP));

    p_soft_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sap_soft_mute |-> (nr_src == NR_SAP));

    p_nr_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nr_src != 2'd3);

endmodule

// File: rtl/audio_route_ctrl.sv
module audio_route_ctrl
    import audio_route_pkg::*;
#(
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] hold_count,
    input  logic              stereo_det,
    input  logic              sap_det,
    input  logic              noise_det,
    input  logic              sap_request,
    input  logic              force_mono,
    input  logic              sap_always,
    input  logic              spk_enable,
    input  logic              ext_select,
    output logic [1:0]        nr_src,
    output logic [2:0]        spk_left_src,
    output logic [2:0]        spk_right_src,
    output logic              sap_soft_mute
);

    logic [FLAG_COUNT-1:0] raw_flags;
    logic [FLAG_COUNT-1:0] clean_flags;

    assign raw_flags[FLAG_STEREO] = stereo_det;
    assign raw_flags[FLAG_SAP]    = sap_det;
    assign raw_flags[FLAG_NOISE]  = noise_det;

    for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_flag
        flag_debounce #(.HOLD_W(HOLD_W)) u_deb (
            .clk        (clk),
            .rst_n      (rst_n),
            .hold_count (hold_count),
            .raw_flag   (raw_flags[g]),
            .clean_flag (clean_flags[g])
        );
    end

    route_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .stereo_ok     (clean_flags[FLAG_STEREO]),
        .sap_ok        (clean_flags[FLAG_SAP]),
        .noise_ok      (clean_flags[FLAG_NOISE]),
        .sap_request   (sap_request),
        .force_mono    (force_mono),
        .sap_always    (sap_always),
        .spk_enable    (spk_enable),
        .ext_select    (ext_select),
        .nr_src        (nr_src),
        .spk_left_src  (spk_left_src),
        .spk_right_src (spk_right_src),
        .sap_soft_mute (sap_soft_mute)
    );

endmodule

// File: tb/test_audio_route_ctrl.sv
module test_audio_route_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hold_count = 8'd4;
    logic       stereo_det = 0, sap_det = 0, noise_det = 0;
    logic       sap_request = 0, force_mono = 0, sap_always = 0;
    logic       spk_enable = 0, ext_select = 0;
    logic [1:0] nr_src;
    logic [2:0] spk_left_src, spk_right_src;
    logic       sap_soft_mute;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    audio_route_ctrl #(.HOLD_W(8)) i_audio_route_ctrl (
        .clk(clk), .rst_n(rst_n), .hold_count(hold_count),
        .stereo_det(stereo_det), .sap_det(sap_det), .noise_det(noise_det),
        .sap_request(sap_request), .force_mono(force_mono), .sap_always(sap_always),
        .spk_enable(spk_enable), .ext_select(ext_select),
        .nr_src(nr_src), .spk_left_src(spk_left_src), .spk_right_src(spk_right_src),
        .sap_soft_mute(sap_soft_mute)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input int nr, input int l, input int r, input int sm);
        chk({req, " nr_src"}, nr_src, nr);
        chk({req, " left"}, spk_left_src, l);
        chk({req, " right"}, spk_right_src, r);
        chk({req, " soft_mute"}, sap_soft_mute, sm);
    endtask

    task automatic settle();
        repeat (12) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_all("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_mono();
        spk_enable = 1;
        settle();
        chk_all("R4 plain mono", 0, 3, 3, 0);
    endtask

    task automatic t_stereo();
        stereo_det = 1;
        settle();
        chk_all("R3 stereo", 1, 1, 2, 0);
        force_mono = 1;
        settle();
        chk_all("R4 forced mono", 0, 3, 3, 0);
        force_mono = 0;
    endtask

    task automatic t_sap_always();
        sap_always = 1; sap_request = 1;
        settle();
        chk_all("R5/R7 sap without carrier", 2, 4, 4, 1);
        force_mono = 1;
        settle();
        chk_all("R5 sap split", 2, 3, 4, 1);
        force_mono = 0; sap_always = 0;
    endtask

    task automatic t_sap_cond();
        settle();
        chk_all("R6 no carrier falls back", 1, 1, 2, 0);
        sap_det = 1;
        settle();
        chk_all("R6 carrier confirmed", 2, 4, 4, 0);
        noise_det = 1;
        settle();
        chk_all("R7 noisy carrier", 2, 4, 4, 1);
        noise_det = 0;
        settle();
    endtask

    task automatic t_mute();
        spk_enable = 0;
        settle();
        chk_all("R8 mute", 2, 0, 0, 0);
        ext_select = 1;
        settle();
        chk_all("R8 mute beats external", 2, 0, 0, 0);
    endtask

    task automatic t_ext();
        spk_enable = 1;
        settle();
        chk_all("R9 external", 2, 5, 5, 0);
    endtask

    task automatic t_latency();
        ext_select = 0;
        #1;
        chk("R10 before edge left", spk_left_src, 5);
        @(posedge clk);
        @(negedge clk);
        chk("R10 after edge left", spk_left_src, 4);
    endtask

    task automatic t_debounce();
        sap_request = 0; sap_det = 0; stereo_det = 0;
        settle();
        chk_all("R2 baseline mono", 0, 3, 3, 0);
        stereo_det = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        stereo_det = 0;
        settle();
        chk("R2 short pulse ignored left", spk_left_src, 3);
        chk("R2 short pulse ignored nr", nr_src, 0);
        stereo_det = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R2 not yet accepted", spk_left_src, 3);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R2 accepted left", spk_left_src, 1);
        chk("R2 accepted right", spk_right_src, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_mono();
        t_stereo();
        t_sap_always();
        t_sap_cond();
        t_mute();
        t_ext();
        t_latency();
        t_debounce();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule